// File: doc/BRIEF.md
# Physical Address Region Decoder

This block sits between one memory master and several target ports. It steers each physical-address request to a target: a load, a store, or a 32-bit compare-and-swap. A small table of address regions makes the choice. Each region has an inclusive low and high bound, a target number, a rebase flag and an enable bit. Entries are checked from index 0 upward, and the lowest-indexed enabled entry that covers the address wins. The request goes to that target, and the target's reply comes back on the response channel.

Two cases produce a coded fault response instead of a forwarded request. The first is an address that no enabled entry covers. The second is a compare-and-swap whose chosen target cannot perform atomics. Fault responses use the same response channel, with a fault flag, a 32-bit cause code and the offending address. The table is written one entry at a time through a configuration write port, and writes are taken only while the decoder has no request in flight.

Top module: `pa_region_router`

## Requirements
- R1: After reset every table entry is disabled, `req_ready` is 1, and `rsp_valid` and all `tgt_valid` bits are 0. A request sent before any configuration therefore faults as unmapped.
- R2: An enabled entry covers an address when low <= address <= high. Both bounds are inclusive, including a high bound at the largest address. Low-1 and high+1 are not covered.
- R3: When enabled entries overlap, the entry with the lowest index is used.
- R4: A disabled entry (`cfg_valid`=0 when written) never matches, even when its bounds cover the address.
- R5: A request that no enabled entry covers is not forwarded to any target. In the cycle after it is accepted, `rsp_valid`=1, `rsp_fault`=1, `rsp_cause`=0x00006000, `rsp_fault_addr` is the request address, `rsp_data`=0 and `rsp_ok`=0. This holds for loads, stores and compare-and-swap alike.
- R6: A compare-and-swap (`req_op`=2) that maps to a target whose bit in `ATOMIC_MASK` is 0 is not forwarded. It gets a fault response one cycle after acceptance with `rsp_cause`=0x00004000 and `rsp_fault_addr` equal to the request address. On a target whose bit is set it is forwarded normally.
- R7: If the matching entry has its rebase flag set, `tgt_addr` is the request address minus the entry's low bound. If the flag is clear, `tgt_addr` is the raw address.
- R8: A forwarded request raises exactly one `tgt_valid` bit, the one for the entry's target. That bit stays high, with `tgt_addr`, `tgt_op` (0 load, 1 store, 2 compare-and-swap), `tgt_wdata` and `tgt_cmp` stable, until that target's `tgt_ready` is seen. `req_ready` is 0 while a request is in flight.
- R9: After the handshake, the decoder waits for the selected target's `tgt_rsp_valid`. One cycle later it presents `rsp_valid` with that target's data and ok bit, `rsp_fault`=0, `rsp_cause`=0xFFFFFFFF and `rsp_fault_addr`=0.
- R10: A configuration write made while a request is in flight has no effect on the table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Table entry write strobe |
| cfg_idx | input | IW | Entry index to write |
| cfg_valid | input | 1 | Enable bit for the entry |
| cfg_remap | input | 1 | Rebase flag for the entry |
| cfg_lo | input | AW | Inclusive low bound |
| cfg_hi | input | AW | Inclusive high bound |
| cfg_tgt | input | TIDW | Target number |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Decoder idle and able to accept |
| req_op | input | 2 | 0 load, 1 store, 2 compare-and-swap |
| req_addr | input | AW | Physical address |
| req_wdata | input | DW | Store data or swap value |
| req_cmp | input | DW | Compare value for compare-and-swap |
| tgt_valid | output | NT | One-hot request strobe per target |
| tgt_ready | input | NT | Per-target accept |
| tgt_addr | output | AW | Forwarded (possibly rebased) address |
| tgt_op | output | 2 | Forwarded operation |
| tgt_wdata | output | DW | Forwarded data |
| tgt_cmp | output | DW | Forwarded compare value |
| tgt_rsp_valid | input | NT | Per-target response valid |
| tgt_rsp_data | input | NT*DW | Per-target response data, target t at bits t*DW upward |
| tgt_rsp_ok | input | NT | Per-target success bit |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_data | output | DW | Returned data, 0 on fault |
| rsp_ok | output | 1 | Success bit, 0 on fault |
| rsp_fault | output | 1 | Fault flag |
| rsp_cause | output | 32 | Fault cause, 0xFFFFFFFF when none |
| rsp_fault_addr | output | AW | Faulting address, 0 when none |

## Verification
A fault response appears one cycle after the accepting edge. A forwarded request with an always-ready target that answers one cycle after the handshake returns three cycles after acceptance. Each cycle of `tgt_ready` held low adds one cycle. The bench counts the falling edges from acceptance until `rsp_valid` and compares the count with these figures, so every expected response is sampled mid-cycle, in the cycle it is due. A target model in the bench records the strobe count and the forwarded fields, which gives the latency checks and the no-forwarding checks for faults the same timing.

// File: rtl/pard_pkg.sv
package pard_pkg;

  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_STORE = 2'd1,
    OP_CAS   = 2'd2,
    OP_RSVD  = 2'd3
  } pard_op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } pard_state_e;

  localparam logic [31:0] CAUSE_UNMAPPED  = 32'h0000_6000;
  localparam logic [31:0] CAUSE_NO_ATOMIC = 32'h0000_4000;
  localparam logic [31:0] CAUSE_NONE      = 32'hFFFF_FFFF;

endpackage

// File: rtl/pard_region_table.sv
module pard_region_table #(
  parameter int AW   = 32,
  parameter int NREG = 4,
  parameter int IW   = 2,
  parameter int TIDW = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [IW-1:0]              wr_idx,
  input  logic                       wr_valid,
  input  logic                       wr_remap,
  input  logic [AW-1:0]              wr_lo,
  input  logic [AW-1:0]              wr_hi,
  input  logic [TIDW-1:0]            wr_tgt,
  output logic [NREG-1:0]            ent_valid,
  output logic [NREG-1:0]            ent_remap,
  output logic [NREG-1:0][AW-1:0]    ent_lo,
  output logic [NREG-1:0][AW-1:0]    ent_hi,
  output logic [NREG-1:0][TIDW-1:0]  ent_tgt
);

  for (genvar g = 0; g < NREG; g++) begin : g_entry
    logic sel;
    assign sel = wr_en && (int'(wr_idx) == g);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ent_valid[g] <= 1'b0;
        ent_remap[g] <= 1'b0;
        ent_lo[g]    <= '0;
        ent_hi[g]    <= '0;
        ent_tgt[g]   <= '0;
      end else if (sel) begin
        ent_valid[g] <= wr_valid;
        ent_remap[g] <= wr_remap;
        ent_lo[g]    <= wr_lo;
        ent_hi[g]    <= wr_hi;
        ent_tgt[g]   <= wr_tgt;
      end
    end
  end

endmodule

// File: rtl/pard_region_match.sv
module pard_region_match #(
  parameter int AW   = 32,
  parameter int NREG = 4,
  parameter int TIDW = 2
) (
  input  logic [AW-1:0]              addr,
  input  logic [NREG-1:0]            ent_valid,
  input  logic [NREG-1:0]            ent_remap,
  input  logic [NREG-1:0][AW-1:0]    ent_lo,
  input  logic [NREG-1:0][AW-1:0]    ent_hi,
  input  logic [NREG-1:0][TIDW-1:0]  ent_tgt,
  output logic                       hit,
  output logic [TIDW-1:0]            hit_tgt,
  output logic [AW-1:0]              fwd_addr
);

  // Inclusive span test on both bounds.
  function automatic logic span_covers(input logic [AW-1:0] a,
                                       input logic [AW-1:0] lo,
                                       input logic [AW-1:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction

  // Address presented to the target: offset from the low bound or raw.
  function automatic logic [AW-1:0] rebase(input logic [AW-1:0] a,
                                           input logic [AW-1:0] lo,
                                           input logic          en);
    return en ? (a - lo) : a;
  endfunction

  logic [NREG-1:0] cover_vec;

  for (genvar g = 0; g < NREG; g++) begin : g_cover
    assign cover_vec[g] = ent_valid[g] && span_covers(addr, ent_lo[g], ent_hi[g]);
  end

  // Lowest index wins: walk downward so the last assignment is the lowest hit.
  always_comb begin
    hit      = 1'b0;
    hit_tgt  = '0;
    fwd_addr = addr;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (cover_vec[i]) begin
        hit      = 1'b1;
        hit_tgt  = ent_tgt[i];
        fwd_addr = rebase(addr, ent_lo[i], ent_remap[i]);
      end
    end
  end

endmodule

// File: rtl/pa_region_router.sv
module pa_region_router #(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int NREG = 4,
  parameter int NT   = 3,
  parameter logic [NT-1:0] ATOMIC_MASK = 3'b001,
  localparam int IW   = (NREG > 1) ? $clog2(NREG) : 1,
  localparam int TIDW = (NT > 1) ? $clog2(NT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [IW-1:0]    cfg_idx,
  input  logic             cfg_valid,
  input  logic             cfg_remap,
  input  logic [AW-1:0]    cfg_lo,
  input  logic [AW-1:0]    cfg_hi,
  input  logic [TIDW-1:0]  cfg_tgt,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_op,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_wdata,
  input  logic [DW-1:0]    req_cmp,
  output logic [NT-1:0]    tgt_valid,
  input  logic [NT-1:0]    tgt_ready,
  output logic [AW-1:0]    tgt_addr,
  output logic [1:0]       tgt_op,
  output logic [DW-1:0]    tgt_wdata,
  output logic [DW-1:0]    tgt_cmp,
  input  logic [NT-1:0]    tgt_rsp_valid,
  input  logic [NT*DW-1:0] tgt_rsp_data,
  input  logic [NT-1:0]    tgt_rsp_ok,
  output logic             rsp_valid,
  output logic [DW-1:0]    rsp_data,
  output logic             rsp_ok,
  output logic             rsp_fault,
  output logic [31:0]      rsp_cause,
  output logic [AW-1:0]    rsp_fault_addr
);
  import pard_pkg::*;

  function automatic logic can_atomic(input logic [TIDW-1:0] t);
    return (int'(t) < NT) ? ATOMIC_MASK[t] : 1'b0;
  endfunction

  pard_state_e state;

  // Region table
  logic                      tbl_we;
  logic [NREG-1:0]           ent_valid, ent_remap;
  logic [NREG-1:0][AW-1:0]   ent_lo, ent_hi;
  logic [NREG-1:0][TIDW-1:0] ent_tgt;

  assign tbl_we = cfg_we && (state == ST_IDLE);

  pard_region_table #(.AW(AW), .NREG(NREG), .IW(IW), .TIDW(TIDW)) u_table (
    .clk(clk), .rst_n(rst_n),
    .wr_en(tbl_we), .wr_idx(cfg_idx), .wr_valid(cfg_valid), .wr_remap(cfg_remap),
    .wr_lo(cfg_lo), .wr_hi(cfg_hi), .wr_tgt(cfg_tgt),
    .ent_valid(ent_valid), .ent_remap(ent_remap), .ent_lo(ent_lo),
    .ent_hi(ent_hi), .ent_tgt(ent_tgt)
  );

  // Lookup
  logic            m_hit;
  logic [TIDW-1:0] m_tgt;
  logic [AW-1:0]   m_fwd;

  pard_region_match #(.AW(AW), .NREG(NREG), .TIDW(TIDW)) u_match (
    .addr(req_addr), .ent_valid(ent_valid), .ent_remap(ent_remap),
    .ent_lo(ent_lo), .ent_hi(ent_hi), .ent_tgt(ent_tgt),
    .hit(m_hit), .hit_tgt(m_tgt), .fwd_addr(m_fwd)
  );

  // Named events
  logic accept_evt, miss_evt, cas_reject_evt, fwd_evt, cfg_blocked;
  logic sel_ready, sel_rsp;
  logic [TIDW-1:0] sel_q;

  assign req_ready      = (state == ST_IDLE);
  assign accept_evt     = req_valid && req_ready;
  assign miss_evt       = accept_evt && !m_hit;
  assign cas_reject_evt = accept_evt && m_hit && (req_op == OP_CAS) && !can_atomic(m_tgt);
  assign fwd_evt        = accept_evt && m_hit && !cas_reject_evt;
  assign cfg_blocked    = cfg_we && (state != ST_IDLE);
  assign sel_ready      = tgt_ready[sel_q];
  assign sel_rsp        = tgt_rsp_valid[sel_q];

  assign tgt_valid = (state == ST_ISSUE) ? (NT'(1) << sel_q) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state          <= ST_IDLE;
      sel_q          <= '0;
      tgt_addr       <= '0;
      tgt_op         <= '0;
      tgt_wdata      <= '0;
      tgt_cmp        <= '0;
      rsp_valid      <= 1'b0;
      rsp_data       <= '0;
      rsp_ok         <= 1'b0;
      rsp_fault      <= 1'b0;
      rsp_cause      <= CAUSE_NONE;
      rsp_fault_addr <= '0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (miss_evt || cas_reject_evt) begin
            rsp_valid      <= 1'b1;
            rsp_fault      <= 1'b1;
            rsp_cause      <= miss_evt ? CAUSE_UNMAPPED : CAUSE_NO_ATOMIC;
            rsp_fault_addr <= req_addr;
            rsp_data       <= '0;
            rsp_ok         <= 1'b0;
          end else if (fwd_evt) begin
            state     <= ST_ISSUE;
            sel_q     <= m_tgt;
            tgt_addr  <= m_fwd;
            tgt_op    <= req_op;
            tgt_wdata <= req_wdata;
            tgt_cmp   <= req_cmp;
          end
        end
        ST_ISSUE: if (sel_ready) state <= ST_WAIT;
        ST_WAIT: begin
          if (sel_rsp) begin
            state          <= ST_IDLE;
            rsp_valid      <= 1'b1;
            rsp_fault      <= 1'b0;
            rsp_cause      <= CAUSE_NONE;
            rsp_fault_addr <= '0;
            rsp_data       <= tgt_rsp_data[sel_q*DW +: DW];
            rsp_ok         <= tgt_rsp_ok[sel_q];
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R8
  tgt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tgt_valid));

  // R8
  tgt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|tgt_valid) && !sel_ready) |=> ((tgt_valid == $past(tgt_valid)) && $stable(tgt_addr)
                                      && $stable(tgt_op) && $stable(tgt_wdata)));

  // R8
  busy_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|tgt_valid) |-> !req_ready);

  // R5
  fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_data == '0 && !rsp_ok));

  // R5
  miss_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miss_evt |=> (rsp_valid && rsp_fault && rsp_cause == CAUSE_UNMAPPED && tgt_valid == '0));

  // R6
  cas_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cas_reject_evt |=> (rsp_valid && rsp_cause == CAUSE_NO_ATOMIC && tgt_valid == '0));

  // R10
  cfg_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_blocked |=> ($stable(ent_valid) && $stable(ent_lo) && $stable(ent_hi) && $stable(ent_tgt)));

endmodule

// File: tb/tb_pa_region_router.sv
module tb_pa_region_router;

  localparam int AW = 32, DW = 32, NREG = 4, NT = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_idx = '0;
  logic          cfg_valid = 1'b0, cfg_remap = 1'b0;
  logic [31:0]   cfg_lo = '0, cfg_hi = '0;
  logic [1:0]    cfg_tgt = '0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [1:0]    req_op = '0;
  logic [31:0]   req_addr = '0, req_wdata = '0, req_cmp = '0;
  logic [NT-1:0] tgt_valid, tgt_ready, tgt_rsp_ok;
  logic [31:0]   tgt_addr, tgt_wdata, tgt_cmp;
  logic [1:0]    tgt_op;
  logic [NT-1:0] tgt_rsp_valid;
  logic [NT*DW-1:0] tgt_rsp_data;
  logic          rsp_valid, rsp_ok, rsp_fault;
  logic [31:0]   rsp_data, rsp_cause, rsp_fault_addr;

  pa_region_router #(.AW(AW), .DW(DW), .NREG(NREG), .NT(NT), .ATOMIC_MASK(3'b001)) dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_valid(cfg_valid), .cfg_remap(cfg_remap),
    .cfg_lo(cfg_lo), .cfg_hi(cfg_hi), .cfg_tgt(cfg_tgt),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_cmp(req_cmp),
    .tgt_valid(tgt_valid), .tgt_ready(tgt_ready), .tgt_addr(tgt_addr), .tgt_op(tgt_op),
    .tgt_wdata(tgt_wdata), .tgt_cmp(tgt_cmp),
    .tgt_rsp_valid(tgt_rsp_valid), .tgt_rsp_data(tgt_rsp_data), .tgt_rsp_ok(tgt_rsp_ok),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_ok(rsp_ok), .rsp_fault(rsp_fault),
    .rsp_cause(rsp_cause), .rsp_fault_addr(rsp_fault_addr)
  );

  // ---------------- target model ----------------
  function automatic logic [31:0] salt(input int t);
    return 32'hC0DE_0000 | t;
  endfunction

  int stall_req = 0;
  int busy_cyc = 0;
  int strobe_total = 0;
  logic [NT-1:0] pend = '0, seen_vec = '0;
  logic [31:0] seen_addr = '0, seen_wd = '0, seen_cm = '0;
  logic [1:0]  seen_op = '0;

  assign tgt_ready     = (busy_cyc >= stall_req) ? '1 : '0;
  assign tgt_rsp_valid = pend;
  assign tgt_rsp_ok    = {NT{~seen_wd[0]}};
  for (genvar t = 0; t < NT; t++) begin : g_tdata
    assign tgt_rsp_data[t*DW +: DW] = seen_addr ^ salt(t);
  end

  always_ff @(posedge clk) begin
    pend <= '0;
    if (|tgt_valid) strobe_total <= strobe_total + 1;
    if ((|tgt_valid) && !(|(tgt_valid & tgt_ready))) busy_cyc <= busy_cyc + 1;
    else busy_cyc <= 0;
    if (|(tgt_valid & tgt_ready)) begin
      pend      <= tgt_valid;
      seen_vec  <= tgt_valid;
      seen_addr <= tgt_addr;
      seen_op   <= tgt_op;
      seen_wd   <= tgt_wdata;
      seen_cm   <= tgt_cmp;
    end
  end

  // ---------------- checking ----------------
  int errors = 0, checks = 0;

  task automatic chk(input bit good, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!good) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic cfg_write(input int idx, input bit v, input bit rm,
                           input logic [31:0] lo, input logic [31:0] hi, input int t);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = idx[1:0]; cfg_valid = v; cfg_remap = rm;
    cfg_lo = lo; cfg_hi = hi; cfg_tgt = t[1:0];
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  int lat;
  int strobes;
  logic [31:0] r_data, r_cause, r_faddr;
  logic r_ok, r_fault;

  task automatic run_req(input logic [1:0] op, input logic [31:0] a,
                         input logic [31:0] wd, input logic [31:0] cm);
    int s0;
    @(negedge clk);
    req_op = op; req_addr = a; req_wdata = wd; req_cmp = cm; req_valid = 1'b1;
    s0 = strobe_total;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!rsp_valid && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    r_data = rsp_data; r_ok = rsp_ok; r_fault = rsp_fault;
    r_cause = rsp_cause; r_faddr = rsp_fault_addr;
    strobes = strobe_total - s0;
  endtask

  typedef struct packed {
    logic [1:0]  op;
    logic [31:0] addr;
    logic [31:0] wd;
    logic [31:0] cm;
    logic        f;
    logic [31:0] cause;
    logic [1:0]  tgt;
    logic [31:0] fwd;
  } vec_t;

  localparam vec_t VECS [14] = '{
    '{2'd0, 32'h0000_1000, 32'h0000_0000, 32'h0, 1'b0, 32'hFFFF_FFFF, 2'd0, 32'h0000_0000},
    '{2'd0, 32'h0000_1FFF, 32'h0000_0001, 32'h0, 1'b0, 32'hFFFF_FFFF, 2'd0, 32'h0000_0FFF},
    '{2'd1, 32'h0000_1800, 32'hAAAA_0000, 32'h0, 1'b0, 32'hFFFF_FFFF, 2'd0, 32'h0000_0800},
    '{2'd0, 32'h0000_2000, 32'h0000_0000, 32'h0, 1'b0, 32'hFFFF_FFFF, 2'd1, 32'h0000_2000},
    '{2'd1, 32'h0000_27FF, 32'h5555_0001, 32'h0, 1'b0, 32'hFFFF_FFFF, 2'd1, 32'h0000_27FF},
    '{2'd0, 32'h0000_0FFF, 32'h0000_0000, 32'h0, 1'b1, 32'h0000_6000, 2'd0, 32'h0},
    '{2'd1, 32'h0000_2800, 32'h1234_5678, 32'h0, 1'b1, 32'h0000_6000, 2'd0, 32'h0},
    '{2'd0, 32'h0000_3000, 32'h0000_0000, 32'h0, 1'b1, 32'h0000_6000, 2'd0, 32'h0},
    '{2'd2, 32'h0000_1004, 32'h0000_0002, 32'h1, 1'b0, 32'hFFFF_FFFF, 2'd0, 32'h0000_0004},
    '{2'd2, 32'h0000_2004, 32'h0000_0002, 32'h1, 1'b1, 32'h0000_4000, 2'd0, 32'h0},
    '{2'd0, 32'hFFFF_FFFC, 32'h0000_0000, 32'h0, 1'b0, 32'hFFFF_FFFF, 2'd2, 32'h7FFF_FFFC},
    '{2'd2, 32'h8000_0000, 32'h0000_0000, 32'h0, 1'b1, 32'h0000_4000, 2'd0, 32'h0},
    '{2'd2, 32'h0000_0100, 32'h0000_0000, 32'h0, 1'b1, 32'h0000_6000, 2'd0, 32'h0},
    '{2'd0, 32'h7FFF_FFFF, 32'h0000_0000, 32'h0, 1'b1, 32'h0000_6000, 2'd0, 32'h0}
  };

  function automatic string tag_of(input int i);
    case (i)
      2:        return "R3";
      3:        return "R7";
      6, 12, 13: return "R5";
      7:        return "R4";
      8, 9, 11: return "R6";
      default:  return "R2";
    endcase
  endfunction

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(req_ready == 1'b1, "R1", "req_ready", {31'd0, req_ready}, 32'd1);
    chk(rsp_valid == 1'b0, "R1", "rsp_valid", {31'd0, rsp_valid}, 32'd0);
    chk(tgt_valid == '0,   "R1", "tgt_valid", {29'd0, tgt_valid}, 32'd0);
    run_req(2'd0, 32'h0000_1000, 32'h0, 32'h0);
    chk(r_fault && r_cause == 32'h0000_6000, "R1", "unconfigured cause", r_cause, 32'h0000_6000);

    // table: overlap 0/1, disabled 2, top span 3
    cfg_write(0, 1'b1, 1'b1, 32'h0000_1000, 32'h0000_1FFF, 0);
    cfg_write(1, 1'b1, 1'b0, 32'h0000_1800, 32'h0000_27FF, 1);
    cfg_write(2, 1'b0, 1'b0, 32'h0000_3000, 32'h0000_3FFF, 2);
    cfg_write(3, 1'b1, 1'b1, 32'h8000_0000, 32'hFFFF_FFFF, 2);

    for (int i = 0; i < 14; i++) begin
      vec_t v;
      string tg;
      v = VECS[i];
      tg = tag_of(i);
      run_req(v.op, v.addr, v.wd, v.cm);
      chk(r_fault == v.f, tg, "fault flag", {31'd0, r_fault}, {31'd0, v.f});
      chk(r_cause == v.cause, tg, "cause", r_cause, v.cause);
      if (v.f) begin
        // R5 fault timing, payload and no forwarding
        chk(lat == 1, "R5", "fault latency", lat, 32'd1);
        chk(r_faddr == v.addr, tg, "fault addr", r_faddr, v.addr);
        chk(r_data == 32'h0 && !r_ok, "R5", "fault data/ok", r_data, 32'h0);
        chk(strobes == 0, tg, "no forward", strobes, 32'd0);
      end else begin
        // R9 latency and returned payload
        chk(lat == 3, "R9", "latency", lat, 32'd3);
        chk(r_data == (v.fwd ^ salt(int'(v.tgt))), "R9", "data", r_data, v.fwd ^ salt(int'(v.tgt)));
        chk(r_ok == ~v.wd[0], "R9", "ok", {31'd0, r_ok}, {31'd0, ~v.wd[0]});
        chk(r_faddr == 32'h0, "R9", "fault addr zero", r_faddr, 32'h0);
        // R8 one-hot target and forwarded fields, R7 address
        chk(seen_vec == (3'b001 << v.tgt), "R8", "target strobe", {29'd0, seen_vec}, {29'd0, 3'b001 << v.tgt});
        chk(seen_addr == v.fwd, "R7", "forwarded addr", seen_addr, v.fwd);
        chk(seen_op == v.op && seen_wd == v.wd && seen_cm == v.cm, "R8", "forwarded op/data",
            {30'd0, seen_op}, {30'd0, v.op});
        chk(strobes == 1, "R8", "single strobe", strobes, 32'd1);
      end
    end

    // R8 stall: strobe held while target not ready; R10 write during busy ignored
    stall_req = 2;
    fork
      run_req(2'd1, 32'h0000_2100, 32'h0000_0000, 32'h0);
      begin
        @(negedge clk); @(negedge clk);
        chk(req_ready == 1'b0, "R8", "ready low when busy", {31'd0, req_ready}, 32'd0);
        chk(tgt_valid == 3'b010, "R8", "strobe held", {29'd0, tgt_valid}, 32'd2);
        cfg_we = 1'b1; cfg_idx = 2'd2; cfg_valid = 1'b1; cfg_remap = 1'b0;
        cfg_lo = 32'h0000_3000; cfg_hi = 32'h0000_3FFF; cfg_tgt = 2'd2;
        @(negedge clk);
        cfg_we = 1'b0;
      end
    join
    stall_req = 0;
    chk(lat == 5, "R8", "stalled latency", lat, 32'd5);
    chk(strobes == 3, "R8", "strobe cycles", strobes, 32'd3);
    chk(seen_addr == 32'h0000_2100, "R8", "held addr", seen_addr, 32'h0000_2100);
    run_req(2'd0, 32'h0000_3000, 32'h0, 32'h0);
    chk(r_fault && r_cause == 32'h0000_6000, "R10", "busy write ignored", r_cause, 32'h0000_6000);

    // R4 then enabled while idle: entry 2 now matches
    cfg_write(2, 1'b1, 1'b0, 32'h0000_3000, 32'h0000_3FFF, 2);
    run_req(2'd0, 32'h0000_3000, 32'h0, 32'h0);
    chk(!r_fault && seen_vec == 3'b100, "R4", "enabled entry hit", {29'd0, seen_vec}, 32'd4);
    chk(r_cause == 32'hFFFF_FFFF, "R9", "no-fault cause", r_cause, 32'hFFFF_FFFF);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule